// File: doc/BRIEF.md
# Two-Wire Bus Arbitration and Address-Match Status Flags

This block watches the clock and data lines of a two-wire serial bus and keeps two sticky status flags for a host processor. One flag reports that this node lost arbitration while acting as bus master. The other reports that this node was addressed while acting as a receiving slave. The block contains only the detection logic for these two flags. It has no byte data path, no clock generator, no acknowledge driver and no bus sequencing beyond start detection.

Both pin levels pass through a synchronizer before any edge is detected. A start is SDA falling while SCL is high. After each start, the block shifts in the first eight data bits, MSB first, on SCL rising edges. It compares them with the seven-bit own address and with the general-call code. Software can clear a flag only by writing zero to it after it has read that flag as one. An interrupt request is raised while any flag is set and its enable bit is on.

Top module: `twi_claim_status`

## Requirements
- R1: After reset, both flags read 0, both enable bits read 0 and `irq` is 0.
- R2: With `master_mode`=1 and `tx_mode`=1, a rising SCL edge is checked against `sda_out_level`. If the sampled SDA level differs, the arbitration flag (status bit 0) is set. In master receive mode the same mismatch has no effect.
- R3: With `master_mode`=1, a start condition seen while `sda_out_level`=1 sets the arbitration flag, even in receive mode. When `master_mode`=0, a start has no effect on that flag.
- R4: With `master_mode`=0 and `tx_mode`=0, the address flag (status bit 1) is set when the first frame after a start has its upper seven bits equal to `own_addr`. The eighth bit, the read/write bit, is ignored. A frame that does not match leaves the flag at 0, and so does any other mode.
- R5: In slave receive mode, a first frame of 8'h00 (general call) sets the address flag. The frame 8'h01 does not set it unless `own_addr` is 0.
- R6: A status write (`reg_sel`=0) clears a flag only if its data bit is 0 and that flag was earlier returned as 1 by a status read (`reg_sel`=0, `reg_rd`=1). A zero write without such a read leaves the flag set. Writing 1 never changes a flag.
- R7: A new set event for a flag cancels any earlier read-as-one for that flag. A set event also wins over a clear in the same cycle, so the flag stays 1.
- R8: A write with `reg_sel`=1 loads the enable bits (bit 0 arbitration, bit 1 address). A read with `reg_sel`=1 returns them. `irq` is 1 exactly while some flag is 1 and its enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL pin level |
| sda_in | input | 1 | SDA pin level |
| sda_out_level | input | 1 | SDA value this node is driving (1 = high/released) |
| master_mode | input | 1 | 1 = master, 0 = slave |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| own_addr | input | 7 | Own slave address |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = status register, 1 = enable register |
| reg_wdata | input | 2 | Write data |
| reg_rdata | output | 2 | Read data of the selected register |
| irq | output | 1 | Interrupt request |

## Verification
The address comparison is swept over all 256 first-frame values for two own addresses, one of them 0. This separates a true seven-bit match from one where the read/write bit leaks into the comparison. It also shows that the general-call code is recognized only with a zero read/write bit. Arbitration is tried in four ways: a mismatching bit and a matching bit in master transmit, a mismatching bit in master receive, and starts seen while driving high in master and in slave mode. Together these show which mode and event gates each set condition. Clear sequences are run in three forms to tell the armed path from a plain write: a zero write without a read, a write of one, and a read followed by a new set event.

// File: rtl/twi_pkg.sv
package twi_pkg;
    localparam int OWN_ADDR_W = 7;
    localparam int NUM_FLAGS  = 2;
    localparam int FLAG_ARB   = 0;
    localparam int FLAG_ADR   = 1;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic start;
    } bus_evt_t;
endpackage

// File: rtl/twi_pin_sync.sv
module twi_pin_sync
    import twi_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t ev
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_prev;
    logic              sda_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh   <= '1;
            sda_sh   <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sh   <= {scl_sh[STAGES-2:0], scl_in};
            sda_sh   <= {sda_sh[STAGES-2:0], sda_in};
            scl_prev <= scl_sh[STAGES-1];
            sda_prev <= sda_sh[STAGES-1];
        end
    end

    always_comb begin
        ev.scl      = scl_sh[STAGES-1];
        ev.sda      = sda_sh[STAGES-1];
        ev.scl_rise = ev.scl & ~scl_prev;
        ev.start    = ev.scl & scl_prev & sda_prev & ~ev.sda;
    end
endmodule

// File: rtl/twi_frame_capture.sv
module twi_frame_capture
    import twi_pkg::*;
#(
    parameter int ADDR_W = OWN_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          ev,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              frame_done,
    output logic              own_hit,
    output logic              gcall_hit
);
    localparam int FRAME_W = ADDR_W + 1;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   cnt;
    logic               active;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg      <= '0;
            cnt        <= '0;
            active     <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (ev.start) begin
                active <= 1'b1;
                cnt    <= '0;
            end else if (active && ev.scl_rise) begin
                shreg <= {shreg[FRAME_W-2:0], ev.sda};
                cnt   <= cnt + 1'b1;
                if (cnt == CNT_W'(FRAME_W - 1)) begin
                    active     <= 1'b0;
                    frame_done <= 1'b1;
                end
            end
        end
    end

    assign own_hit   = (shreg[FRAME_W-1:1] == own_addr);
    assign gcall_hit = (shreg == '0);
endmodule

// File: rtl/twi_sticky_flag.sv
module twi_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic rd_hit,
    input  logic clr_req,
    output logic flag
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else if (set_evt) begin
            flag  <= 1'b1;
            armed <= 1'b0;
        end else if (clr_req && armed) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else if (rd_hit && flag) begin
            armed <= 1'b1;
        end
    end
endmodule

// File: rtl/twi_claim_status.sv
module twi_claim_status
    import twi_pkg::*;
#(
    parameter int ADDR_W      = OWN_ADDR_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_in,
    input  logic                 sda_in,
    input  logic                 sda_out_level,
    input  logic                 master_mode,
    input  logic                 tx_mode,
    input  logic [ADDR_W-1:0]    own_addr,
    input  logic                 reg_rd,
    input  logic                 reg_wr,
    input  logic                 reg_sel,
    input  logic [NUM_FLAGS-1:0] reg_wdata,
    output logic [NUM_FLAGS-1:0] reg_rdata,
    output logic                 irq
);
    bus_evt_t             ev;
    logic                 frame_done;
    logic                 own_hit;
    logic                 gcall_hit;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] clr_vec;
    logic [NUM_FLAGS-1:0] flags;
    logic [NUM_FLAGS-1:0] enables;
    logic                 stat_rd;

    twi_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .ev(ev)
    );

    twi_frame_capture #(.ADDR_W(ADDR_W)) cap_i (
        .clk(clk), .rst(rst), .ev(ev), .own_addr(own_addr),
        .frame_done(frame_done), .own_hit(own_hit), .gcall_hit(gcall_hit)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[FLAG_ARB] = master_mode &
                            ((tx_mode & ev.scl_rise & (sda_out_level != ev.sda)) |
                             (ev.start & sda_out_level));
        set_vec[FLAG_ADR] = ~master_mode & ~tx_mode & frame_done &
                            (own_hit | gcall_hit);
    end

    assign stat_rd = reg_rd & ~reg_sel;

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        assign clr_vec[i] = reg_wr & ~reg_sel & ~reg_wdata[i];
        twi_sticky_flag flag_i (
            .clk(clk), .rst(rst), .set_evt(set_vec[i]), .rd_hit(stat_rd),
            .clr_req(clr_vec[i]), .flag(flags[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enables <= '0;
        end else if (reg_wr && reg_sel) begin
            enables <= reg_wdata;
        end
    end

    assign reg_rdata = reg_sel ? enables : flags;
    assign irq       = |(flags & enables);
endmodule

// File: rtl/twi_claim_status_chk.sv
module twi_claim_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       irq,
    input logic [1:0] flags,
    input logic [1:0] set_vec,
    input logic       master_mode,
    input logic       tx_mode,
    input logic       reg_wr,
    input logic       reg_sel,
    input logic [1:0] reg_wdata
);
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (flags == 2'b00 && !irq));

    a_r3_arb_needs_master: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[0]) |-> $past(master_mode));

    a_r4_adr_needs_slave_rx: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[1]) |-> $past(!master_mode && !tx_mode));

    a_r6_arb_fall_needs_write: assert property (@(posedge clk) disable iff (rst)
        $fell(flags[0]) |-> $past(reg_wr && !reg_sel && !reg_wdata[0]));

    a_r6_adr_fall_needs_write: assert property (@(posedge clk) disable iff (rst)
        $fell(flags[1]) |-> $past(reg_wr && !reg_sel && !reg_wdata[1]));

    a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
        (set_vec != 2'b00) |=> ((flags & $past(set_vec)) == $past(set_vec)));

    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags != 2'b00));
endmodule

bind twi_claim_status twi_claim_status_chk chk_i (
    .clk(clk), .rst(rst), .irq(irq), .flags(flags), .set_vec(set_vec),
    .master_mode(master_mode), .tx_mode(tx_mode), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata)
);

// File: tb/twi_claim_status_tb_top.sv
`timescale 1ns/1ps
module twi_claim_status_tb_top;
    localparam int H = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_in = 1'b1, sda_in = 1'b1, sda_out_level = 1'b1;
    logic       master_mode = 1'b0, tx_mode = 1'b0;
    logic [6:0] own_addr = 7'h5A;
    logic       reg_rd = 1'b0, reg_wr = 1'b0, reg_sel = 1'b0;
    logic [1:0] reg_wdata = 2'b00;
    logic [1:0] reg_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    twi_claim_status dut_i (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .sda_out_level(sda_out_level), .master_mode(master_mode), .tx_mode(tx_mode),
        .own_addr(own_addr), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic reg_read(input logic sel, output logic [1:0] val);
        @(negedge clk);
        reg_sel = sel; reg_rd = 1'b1;
        #1 val = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic reg_write(input logic sel, input logic [1:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(output logic [1:0] val);
        @(negedge clk);
        reg_sel = 1'b0;
        #1 val = reg_rdata;
    endtask

    task automatic bus_start();
        sda_in = 1'b0; wait_clk(H);
        scl_in = 1'b0; wait_clk(H);
    endtask

    task automatic bus_stop();
        sda_in = 1'b0; wait_clk(H);
        scl_in = 1'b1; wait_clk(H);
        sda_in = 1'b1; wait_clk(H);
    endtask

    task automatic bus_bit(input logic pin, input logic drv);
        sda_in = pin; sda_out_level = drv; wait_clk(H);
        scl_in = 1'b1; wait_clk(H);
        scl_in = 1'b0; wait_clk(H);
    endtask

    task automatic bus_frame(input logic [7:0] f);
        bus_start();
        for (int b = 7; b >= 0; b--) bus_bit(f[b], f[b]);
        bus_stop();
        sda_out_level = 1'b1;
        wait_clk(4);
    endtask

    task automatic full_clear();
        logic [1:0] v;
        reg_read(1'b0, v);
        reg_write(1'b0, 2'b00);
    endtask

    initial begin
        logic [1:0] v;
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);

        peek(v);
        check("R1 flags after reset", v, 0);
        reg_read(1'b1, v);
        check("R1 enables after reset", v, 0);
        check("R1 irq after reset", irq, 0);

        // R4/R5 exhaustive sweep over frames, two own addresses
        master_mode = 1'b0; tx_mode = 1'b0;
        for (int k = 0; k < 2; k++) begin
            own_addr = (k == 0) ? 7'h5A : 7'h00;
            for (int f = 0; f < 256; f++) begin
                bus_frame(8'(f));
                peek(v);
                check($sformatf("R4 R5 addr flag own=%0h frame=%0h", own_addr, f), v[1],
                      (((f >> 1) == int'(own_addr)) || f == 0) ? 1 : 0);
                check("R3 slave start leaves arb flag", v[0], 0);
                full_clear();
            end
        end

        // R4 other modes ignore a matching frame
        own_addr = 7'h5A;
        master_mode = 1'b0; tx_mode = 1'b1;
        bus_frame(8'hB4);
        peek(v);
        check("R4 slave tx no addr flag", v[1], 0);
        master_mode = 1'b1; tx_mode = 1'b0; sda_out_level = 1'b0;
        sda_in = 1'b0; wait_clk(H); scl_in = 1'b0; wait_clk(H);
        for (int b = 7; b >= 0; b--) bus_bit(b[0], b[0]);
        bus_stop();
        peek(v);
        check("R4 master rx no addr flag", v[1], 0);
        full_clear();

        // R2 master transmit matching bits: no set
        master_mode = 1'b1; tx_mode = 1'b1;
        scl_in = 1'b0; wait_clk(H);
        bus_bit(1'b0, 1'b0); bus_bit(1'b1, 1'b1);
        peek(v);
        check("R2 matching bits", v[0], 0);
        // R2 master receive mismatch: no set
        tx_mode = 1'b0;
        bus_bit(1'b0, 1'b1);
        peek(v);
        check("R2 master rx mismatch ignored", v[0], 0);
        // R2 master transmit mismatch: set
        tx_mode = 1'b1;
        bus_bit(1'b0, 1'b1);
        peek(v);
        check("R2 tx mismatch sets arb", v[0], 1);

        // R6 zero write without read keeps flag
        reg_write(1'b0, 2'b00);
        peek(v);
        check("R6 write0 without read", v[0], 1);
        // R6 write of one after read keeps flag
        reg_read(1'b0, v);
        reg_write(1'b0, 2'b11);
        peek(v);
        check("R6 write1 keeps flag", v[0], 1);

        // R8 interrupt enables
        reg_write(1'b1, 2'b10);
        reg_read(1'b1, v);
        check("R8 enable readback", v, 2);
        check("R8 irq masked", irq, 0);
        reg_write(1'b1, 2'b01);
        wait_clk(1);
        check("R8 irq raised", irq, 1);

        // R7 re-set after read disarms clear
        reg_read(1'b0, v);
        bus_bit(1'b0, 1'b1);
        reg_write(1'b0, 2'b00);
        peek(v);
        check("R7 re-set cancels armed clear", v[0], 1);

        // R6 proper clear
        full_clear();
        peek(v);
        check("R6 read then write0 clears", v[0], 0);
        check("R8 irq drops", irq, 0);

        // R3 start while driving high in master receive
        tx_mode = 1'b0; sda_out_level = 1'b1;
        scl_in = 1'b1; sda_in = 1'b1; wait_clk(H);
        bus_start();
        peek(v);
        check("R3 start while high sets arb", v[0], 1);
        full_clear();
        // R3 start while driving low: no set
        sda_out_level = 1'b0;
        scl_in = 1'b1; sda_in = 1'b1; wait_clk(H);
        bus_start();
        peek(v);
        check("R3 start while low no set", v[0], 0);
        check("R8 irq with no flag", irq, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule